// File: doc/BRIEF.md
# Paged Call/Return Sequencer

This block performs the multi-cycle work behind a far subroutine call and its matching return in a processor whose program space is seen through a banked window. A call supplies three values: a target bank number, a precomputed 16-bit target address and the address of the instruction that follows the call. The sequencer then does four things. It swaps the bank register, keeping the old bank in a holding register. It writes the return address and then the old bank number to a byte-wide stack through a single-port memory interface. Last, it loads the program counter with the target.

A return reverses this. It reads the bank number back into the bank register, then reads the two return-address bytes into the program counter. An interrupt-inhibit output covers each sequence from the cycle it is accepted to its final cycle, so that neither sequence can be split.

Alongside the sequencer, a combinational translator turns a 16-bit local address into a 22-bit global address. Local addresses inside the window are rebased onto the current bank. All other local addresses are passed through.

Top module: `page_call_seq`

## Requirements
- R1: After reset the bank register and program counter read 0, the stack pointer reads the STACK_TOP parameter, and busy, done, irq_inhibit, mem_we and mem_re are all low.
- R2: A local address from 0x8000 to 0xBFFF gives glb_addr = bank*0x4000 + (loc_addr - 0x8000) with in_window high. Any other local address gives glb_addr equal to loc_addr zero-extended, with in_window low. The translation uses the current bank register value.
- R3: When idle with call_req high, the bank register takes tgt_page at that clock edge. The previous bank value is kept for the stack.
- R4: In the three cycles after a call is accepted, the block writes once per cycle with mem_we high, mem_re low and the stack pointer starting at S. The low byte of next_pc goes to S-1, the high byte to S-2 and the previous bank to S-3. The stack pointer ends at S-3.
- R5: The fourth cycle after a call is accepted has done high and no memory access. From the next cycle the program counter equals tgt_addr and busy is low.
- R6: When idle with ret_req high and call_req low, the block reads in the three following cycles with mem_re high, with the stack pointer starting at S. The byte read at S goes to the bank register. The bytes read at S+1 (high) and S+2 (low) go to the program counter. done is high in the third read cycle, and the stack pointer ends at S+3. mem_rdata is sampled in the same cycle as mem_re.
- R7: irq_inhibit is high in the acceptance cycle and in every cycle up to and including the done cycle. It is low when idle with no request.
- R8: call_req and ret_req are ignored while a sequence is running. If both are high when idle, the call is taken.
- R9: The stack pointer and stack addresses wrap modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_req | input | 1 | Start a far call |
| ret_req | input | 1 | Start a far return |
| tgt_page | input | 8 | Bank number for the call target |
| tgt_addr | input | 16 | Call target address |
| next_pc | input | 16 | Address following the call (return address) |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Stack write byte |
| mem_rdata | input | 8 | Stack read byte, valid in the cycle of mem_re |
| loc_addr | input | 16 | Local address to translate |
| glb_addr | output | 22 | Translated global address |
| in_window | output | 1 | loc_addr lies in the banked window |
| page | output | 8 | Current bank register |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final cycle of a sequence |
| irq_inhibit | output | 1 | Interrupts held off |

## Verification
The bench translates the window edges (0x7FFF, 0x8000, 0xBFFF, 0xC000) under every one of the 256 banks. A decoder compare that is off by one, or that uses the stale bank, would misroute exactly those addresses. Calls nest a dozen deep and unwind, so a reversed byte order or a page byte pushed first would return wrong program-counter or bank values.

The stack starts two bytes above zero, which forces the first call to wrap. A stack pointer lacking modular arithmetic would write the wrong cells there. Requests raised mid-sequence, and calls and returns raised together, catch a sequencer that restarts or picks the return.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Sequencer states: three pushes plus a jump for a call, three pops for a return.
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_PUSH_LO = 3'd1,
    S_PUSH_HI = 3'd2,
    S_PUSH_PG = 3'd3,
    S_JUMP    = 3'd4,
    S_POP_PG  = 3'd5,
    S_POP_HI  = 3'd6,
    S_POP_LO  = 3'd7
  } seq_state_t;

  function automatic logic is_push(input seq_state_t s);
    return (s == S_PUSH_LO) || (s == S_PUSH_HI) || (s == S_PUSH_PG);
  endfunction

  function automatic logic is_pop(input seq_state_t s);
    return (s == S_POP_PG) || (s == S_POP_HI) || (s == S_POP_LO);
  endfunction

endpackage

// File: rtl/pcs_xlate.sv
module pcs_xlate #(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 8,
  parameter int WIN_BITS = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000,
  localparam int GLB_W   = PAGE_W + WIN_BITS
) (
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [PAGE_W-1:0] page,
  output logic [GLB_W-1:0]  glb_addr,
  output logic              in_window
);

  localparam int TAG_W = ADDR_W - WIN_BITS;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_BITS];

  typedef logic [GLB_W-1:0] glb_t;

  // The window is aligned to its own size, so a tag compare finds it.
  function automatic logic win_hit(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WIN_BITS] == WIN_TAG;
  endfunction

  // Inside the window the bank replaces the tag bits; outside, zero extend.
  function automatic glb_t map_addr(input logic [ADDR_W-1:0] a,
                                    input logic [PAGE_W-1:0] pg);
    glb_t r;
    if (win_hit(a)) r = {pg, a[WIN_BITS-1:0]};
    else            r = glb_t'(a);
    return r;
  endfunction

  always_comb begin
    in_window = win_hit(loc_addr);
    glb_addr  = map_addr(loc_addr, page);
  end

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STACK_TOP = 16'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec,       // pre-decrement write
  input  logic              inc,       // post-increment read
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] push_addr,
  output logic [ADDR_W-1:0] pop_addr
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] sp_q;

  // Modular arithmetic: the stack wraps at the top of the local space.
  function automatic logic [ADDR_W-1:0] sp_step(input logic [ADDR_W-1:0] cur,
                                                input logic d, input logic i);
    logic [ADDR_W-1:0] r;
    r = cur;
    if (d)      r = cur - ONE;
    else if (i) r = cur + ONE;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= STACK_TOP;
    else        sp_q <= sp_step(sp_q, dec, inc);
  end

  assign sp        = sp_q;
  assign push_addr = sp_q - ONE;
  assign pop_addr  = sp_q;

  assert_push_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> (sp_q == $past(sp_q) - ONE));

  assert_pop_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (sp_q == $past(sp_q) + ONE));

  assert_sp_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec && !inc) |=> $stable(sp_q));

endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       call_req,
  input  logic       ret_req,
  output seq_state_t state,
  output logic       call_go,
  output logic       ret_go,
  output logic       mem_we,
  output logic       mem_re,
  output logic       busy,
  output logic       done,
  output logic       irq_inhibit
);

  seq_state_t state_q, state_d;

  // Requests are only looked at when idle; a call outranks a return.
  always_comb begin
    call_go = (state_q == S_IDLE) && call_req;
    ret_go  = (state_q == S_IDLE) && !call_req && ret_req;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (call_go)     state_d = S_PUSH_LO;
        else if (ret_go) state_d = S_POP_PG;
      end
      S_PUSH_LO: state_d = S_PUSH_HI;
      S_PUSH_HI: state_d = S_PUSH_PG;
      S_PUSH_PG: state_d = S_JUMP;
      S_JUMP:    state_d = S_IDLE;
      S_POP_PG:  state_d = S_POP_HI;
      S_POP_HI:  state_d = S_POP_LO;
      S_POP_LO:  state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state       = state_q;
    mem_we      = is_push(state_q);
    mem_re      = is_pop(state_q);
    busy        = (state_q != S_IDLE);
    done        = (state_q == S_JUMP) || (state_q == S_POP_LO);
    irq_inhibit = busy || call_go || ret_go;
  end

  assert_inhibit_in_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> irq_inhibit);

  assert_port_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_call_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && call_req) |=> mem_we);

endmodule

// File: rtl/page_call_seq.sv
module page_call_seq
  import pcs_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 8,
  parameter int WIN_BITS = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h8000,
  parameter logic [ADDR_W-1:0] STACK_TOP = 16'h2000,
  parameter logic [ADDR_W-1:0] PC_RESET  = 16'h0000,
  localparam int GLB_W  = PAGE_W + WIN_BITS,
  localparam int HALF_W = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic [PAGE_W-1:0] tgt_page,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [ADDR_W-1:0] next_pc,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PAGE_W-1:0] mem_wdata,
  input  logic [PAGE_W-1:0] mem_rdata,
  input  logic [ADDR_W-1:0] loc_addr,
  output logic [GLB_W-1:0]  glb_addr,
  output logic              in_window,
  output logic [PAGE_W-1:0] page,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic              busy,
  output logic              done,
  output logic              irq_inhibit
);

  // Named internal events, shared between the sub-blocks and the assertions.
  seq_state_t        state;
  logic              call_go, ret_go;
  logic [ADDR_W-1:0] push_addr, pop_addr;
  logic              pg_pop, hi_pop, lo_pop, jump_now;

  logic [PAGE_W-1:0] page_q, tmp_page_q;
  logic [ADDR_W-1:0] pc_q, ret_q, tgt_q;
  logic [HALF_W-1:0] hi_q;

  pcs_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .call_req    (call_req),
    .ret_req     (ret_req),
    .state       (state),
    .call_go     (call_go),
    .ret_go      (ret_go),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .busy        (busy),
    .done        (done),
    .irq_inhibit (irq_inhibit)
  );

  pcs_stack #(
    .ADDR_W    (ADDR_W),
    .STACK_TOP (STACK_TOP)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec       (mem_we),
    .inc       (mem_re),
    .sp        (sp),
    .push_addr (push_addr),
    .pop_addr  (pop_addr)
  );

  pcs_xlate #(
    .ADDR_W   (ADDR_W),
    .PAGE_W   (PAGE_W),
    .WIN_BITS (WIN_BITS),
    .WIN_BASE (WIN_BASE)
  ) u_xlate (
    .loc_addr  (loc_addr),
    .page      (page_q),
    .glb_addr  (glb_addr),
    .in_window (in_window)
  );

  assign pg_pop   = (state == S_POP_PG);
  assign hi_pop   = (state == S_POP_HI);
  assign lo_pop   = (state == S_POP_LO);
  assign jump_now = (state == S_JUMP);

  // Byte chosen for each push slot: low half, high half, then the old bank.
  function automatic logic [PAGE_W-1:0] push_byte(input seq_state_t s,
                                                  input logic [ADDR_W-1:0] ra,
                                                  input logic [PAGE_W-1:0] old_pg);
    logic [PAGE_W-1:0] b;
    unique case (s)
      S_PUSH_LO: b = PAGE_W'(ra[HALF_W-1:0]);
      S_PUSH_HI: b = PAGE_W'(ra[ADDR_W-1:HALF_W]);
      S_PUSH_PG: b = old_pg;
      default:   b = '0;
    endcase
    return b;
  endfunction

  // Recombine the return address from the saved high half and the last byte.
  function automatic logic [ADDR_W-1:0] join_addr(input logic [HALF_W-1:0] hi,
                                                  input logic [PAGE_W-1:0] lo);
    return {hi, HALF_W'(lo)};
  endfunction

  assign mem_addr  = mem_we ? push_addr : pop_addr;
  assign mem_wdata = push_byte(state, ret_q, tmp_page_q);

  // Bank register: swapped at acceptance of a call, restored by the first pop.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q     <= '0;
      tmp_page_q <= '0;
    end else if (call_go) begin
      tmp_page_q <= page_q;
      page_q     <= tgt_page;
    end else if (pg_pop) begin
      page_q     <= mem_rdata;
    end
  end

  // Call operands are captured at acceptance so the inputs may change later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q <= '0;
      tgt_q <= '0;
    end else if (call_go) begin
      ret_q <= next_pc;
      tgt_q <= tgt_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (hi_pop) hi_q <= HALF_W'(mem_rdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= PC_RESET;
    else if (jump_now) pc_q <= tgt_q;
    else if (lo_pop)   pc_q <= join_addr(hi_q, mem_rdata);
  end

  assign page = page_q;
  assign pc   = pc_q;

  assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(call_go || pg_pop) |=> $stable(page_q));

  assert_done_to_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_pc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(pc_q));

  assert_old_page_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    call_go |=> (tmp_page_q == $past(page_q)));

endmodule

// File: tb/test_page_call_seq.sv
module test_page_call_seq;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SP0 = 16'h0002;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_req = 1'b0, ret_req = 1'b0;
  logic [7:0]  tgt_page = '0;
  logic [15:0] tgt_addr = '0, next_pc = '0, loc_addr = '0;
  logic        mem_we, mem_re, in_window, busy, done, irq_inhibit;
  logic [15:0] mem_addr, pc, sp;
  logic [7:0]  mem_wdata, mem_rdata, page;
  logic [21:0] glb_addr;

  logic [7:0]  mem [0:1023];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0]  cur_page = 8'h00;
  logic [15:0] cur_sp   = SP0;
  logic [7:0]  st_pg [0:63];
  logic [15:0] st_pc [0:63];
  int depth = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_call_seq #(.STACK_TOP(SP0)) i_page_call_seq (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
    .tgt_page(tgt_page), .tgt_addr(tgt_addr), .next_pc(next_pc),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .loc_addr(loc_addr),
    .glb_addr(glb_addr), .in_window(in_window), .page(page), .pc(pc),
    .sp(sp), .busy(busy), .done(done), .irq_inhibit(irq_inhibit)
  );

  always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[9:0]];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_xlate(input logic [15:0] a, input logic [7:0] pg);
    logic [21:0] e;
    bit w;
    w = (a >= 16'h8000) && (a <= 16'hBFFF);
    e = w ? (22'(pg) * 22'h4000 + 22'(a - 16'h8000)) : 22'(a);
    loc_addr = a;
    #1;
    chk("R2", "glb_addr", 32'(glb_addr), 32'(e));
    chk("R2", "in_window", 32'(in_window), 32'(w));
  endtask

  task automatic do_call(input logic [7:0] pg, input logic [15:0] ta,
                         input logic [15:0] np, input bit both, input bit glitch);
    logic [15:0] s0;
    logic [7:0] oldp;
    s0 = cur_sp; oldp = cur_page;
    @(negedge clk);
    call_req = 1; ret_req = both; tgt_page = pg; tgt_addr = ta; next_pc = np;
    #1;
    chk("R7", "inhibit at accept", 32'(irq_inhibit), 1);
    @(negedge clk);
    call_req = glitch; ret_req = glitch;
    if (glitch) begin tgt_page = ~pg; tgt_addr = ~ta; next_pc = ~np; end
    #1;
    chk("R3", "page after accept", 32'(page), 32'(pg));
    chk("R4", "we slot0", 32'({mem_we, mem_re}), 32'h2);
    chk("R4", "addr slot0", 32'(mem_addr), 32'(16'(s0 - 16'd1)));
    chk("R4", "data slot0", 32'(mem_wdata), 32'(np[7:0]));
    chk("R7", "inhibit slot0", 32'({busy, irq_inhibit}), 32'h3);
    @(negedge clk); #1;
    chk("R4", "addr slot1", 32'(mem_addr), 32'(16'(s0 - 16'd2)));
    chk("R4", "data slot1", 32'(mem_wdata), 32'(np[15:8]));
    @(negedge clk);
    call_req = 0; ret_req = 0;
    #1;
    chk("R4", "addr slot2", 32'(mem_addr), 32'(16'(s0 - 16'd3)));
    chk("R4", "data slot2", 32'(mem_wdata), 32'(oldp));
    @(negedge clk); #1;
    chk("R5", "done/we/re", 32'({done, mem_we, mem_re}), 32'h4);
    chk("R7", "inhibit at done", 32'(irq_inhibit), 1);
    @(negedge clk); #1;
    chk("R5", "pc after call", 32'(pc), 32'(ta));
    chk("R5", "idle after call", 32'({busy, done, irq_inhibit}), 0);
    chk("R9", "sp after call", 32'(sp), 32'(16'(s0 - 16'd3)));
    chk("R8", "page kept", 32'(page), 32'(pg));
    st_pg[depth] = oldp; st_pc[depth] = np; depth++;
    cur_page = pg; cur_sp = 16'(s0 - 16'd3);
  endtask

  task automatic do_ret();
    logic [15:0] s0;
    s0 = cur_sp; depth--;
    @(negedge clk);
    ret_req = 1;
    #1;
    chk("R7", "inhibit at ret accept", 32'(irq_inhibit), 1);
    @(negedge clk);
    ret_req = 0;
    #1;
    chk("R6", "re slot0", 32'({mem_we, mem_re}), 32'h1);
    chk("R6", "addr slot0", 32'(mem_addr), 32'(s0));
    @(negedge clk); #1;
    chk("R6", "addr slot1", 32'(mem_addr), 32'(16'(s0 + 16'd1)));
    chk("R6", "page popped", 32'(page), 32'(st_pg[depth]));
    @(negedge clk); #1;
    chk("R6", "addr slot2", 32'(mem_addr), 32'(16'(s0 + 16'd2)));
    chk("R6", "done at last pop", 32'(done), 1);
    @(negedge clk); #1;
    chk("R6", "pc popped", 32'(pc), 32'(st_pc[depth]));
    chk("R9", "sp after ret", 32'(sp), 32'(16'(s0 + 16'd3)));
    chk("R7", "idle after ret", 32'({busy, done, irq_inhibit}), 0);
    cur_page = st_pg[depth]; cur_sp = 16'(s0 + 16'd3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "page", 32'(page), 0);
    chk("R1", "pc", 32'(pc), 0);
    chk("R1", "sp", 32'(sp), 32'(SP0));
    chk("R1", "flags", 32'({busy, done, irq_inhibit, mem_we, mem_re}), 0);
    rst_n = 1;

    // First call wraps below address zero (R9), nested deep with translation.
    for (int k = 0; k < 12; k++) begin
      do_call(8'(k * 23 + 5), 16'(16'h8100 + k * 16'h0313),
              16'(16'h4001 + k * 16'h1111), 0, 0);
      check_xlate(16'h7FFF, cur_page);
      check_xlate(16'h8000, cur_page);
      check_xlate(16'hBFFF, cur_page);
      check_xlate(16'hC000, cur_page);
    end
    for (int k = 0; k < 12; k++) do_ret();
    chk("R9", "sp restored", 32'(sp), 32'(SP0));

    // Simultaneous call and return: call wins; mid-sequence requests ignored.
    do_call(8'hA5, 16'h9ABC, 16'h1234, 1, 0);
    do_call(8'h3C, 16'hB00F, 16'hFEDC, 0, 1);
    @(negedge clk); #1;
    chk("R8", "no late start", 32'({busy, mem_we, mem_re}), 0);
    do_ret();
    do_ret();

    // Every bank through the translator.
    for (int p = 0; p < 256; p++) begin
      do_call(8'(p), 16'(16'h8000 + p * 16'h0041), 16'(p * 16'h0101), 0, 0);
      check_xlate(16'h0000, 8'(p));
      check_xlate(16'h7FFF, 8'(p));
      check_xlate(16'h8000, 8'(p));
      check_xlate(16'(16'h8000 + p * 16'h003D), 8'(p));
      check_xlate(16'hBFFF, 8'(p));
      check_xlate(16'hC000, 8'(p));
      check_xlate(16'hFFFF, 8'(p));
      do_ret();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule